// File: doc/BRIEF.md
# HMAC Phase Sequencing Controller

This block is the control front end of a keyed-hash unit. It sits between a software-facing register interface and a separate compression engine, and runs a job through its fixed segments. In keyed mode the segments are the inner key, the message and the outer key. In plain mode there is only the message. All key and message words enter through one shared data-write path. A start strobe closes each segment and carries the number of valid bits in its final word.

The controller forwards the words to the engine over a simple handshake: a segment-start pulse, a segment code, word valid, last word and engine done. It raises ready whenever the current segment can take words. It holds busy while the engine works on a closed segment. When the final segment completes, it captures the digest and raises a done flag. Writing init at any time abandons the job in progress and starts over.

A long-key flag, given at init, tells the engine that each key segment must first be reduced by hashing. The flag applies to the inner and the outer round alike.

Top module: `hmac_seq_ctrl`

## Requirements
- R1: After reset, `rdy`, `busy`, `done`, `eng_valid`, `eng_last` and `eng_start` are 0. `eng_seg` is 0 and `digest` is all zero.
- R2: A cycle with `cfg_init`=1 latches `cfg_hmac`, `cfg_algo` and `cfg_long_key`. On the next cycle `rdy` is 1 and `eng_start` pulses for one cycle. `eng_seg` is then 1 (inner key) if `cfg_hmac`=1, or 2 (message) if `cfg_hmac`=0.
- R3: Each accepted data word is held back by one write. A later write forwards it on `eng_data` with `eng_valid`=1 and `eng_last`=0. `seg_go` forwards the held word, if there is one, with `eng_last`=1 and `eng_bits`=`seg_bits`. The engine therefore sees the segment's words in write order, and the last of them is flagged.
- R4: `din_wr` has no effect while `rdy` is 0: before the first init, while busy, and after the job completes.
- R5: A `din_wr` in the same cycle as an accepted `seg_go` is ignored. That word is not part of the segment.
- R6: `busy` is 1 from the cycle after an accepted `seg_go` until the cycle after `eng_done`. `rdy` and `busy` are never both 1.
- R7: Keyed mode runs segments 1, 2, 3 in that order. Each new segment becomes ready, with an `eng_start` pulse, once the engine reports done on the previous one. Plain mode runs segment 2 only.
- R8: `eng_key_long` equals the latched long-key flag while `eng_seg` is 1 or 3, and is 0 otherwise.
- R9: When the engine reports done on the final segment, `done` rises. `digest` word i (bits i*32+31..i*32) then takes the engine's word i for i < N, and the rest are zero. N = 8 when `cfg_algo[1]`=1, and N = 5 otherwise. `done` stays high and `digest` stays unchanged until the next init.
- R10: `cfg_init` at any point clears `done`, `busy`, `digest` and any held word, and restarts at the first segment of the new mode.
- R11: `eng_done` while `busy` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_init | input | 1 | Start (or restart) a job |
| cfg_hmac | input | 1 | 1 = keyed mode, 0 = plain hash |
| cfg_algo | input | 2 | Algorithm select; bit 1 picks the 8-word digest |
| cfg_long_key | input | 1 | Key exceeds one block and must be reduced first |
| din_wr | input | 1 | Data word write strobe |
| din_data | input | 32 | Key or message word |
| seg_go | input | 1 | Close the current segment |
| seg_bits | input | 6 | Valid bits in the segment's final word |
| rdy | output | 1 | Current segment accepts words |
| busy | output | 1 | Engine working on a closed segment |
| done | output | 1 | Digest valid |
| digest | output | 256 | Captured result, word 0 in the low bits |
| eng_start | output | 1 | Segment start pulse to the engine |
| eng_seg | output | 2 | Segment code: 0 none, 1 inner key, 2 message, 3 outer key |
| eng_algo | output | 2 | Latched algorithm select |
| eng_key_long | output | 1 | Key segment needs reduction |
| eng_valid | output | 1 | Word valid to the engine |
| eng_data | output | 32 | Word to the engine |
| eng_last | output | 1 | Segment closed; final word flagged |
| eng_bits | output | 6 | Valid bits of the final word |
| eng_done | input | 1 | Engine finished the segment |
| eng_digest | input | 256 | Engine result words |

## Verification
The bound checker watches invariants on every cycle:
- ready and busy are never both high;
- no word reaches the engine unless ready was high in the cycle before;
- a closed segment always leaves the controller busy;
- the long-key flag appears only with key segments;
- init always clears the result;
- a captured short digest has zero upper words;
- done stays high until init.

Only the bench's scenarios can show the rest. These are the segment ordering in both modes, the exact word content and count per segment, the digest masking against the algorithm, and the discarding of stray writes and done pulses. Each of these needs a model of what was pushed.

// File: rtl/hmacseq_pkg.sv
package hmacseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_IKEY     = 3'd1,
        PH_IKEY_RUN = 3'd2,
        PH_MSG      = 3'd3,
        PH_MSG_RUN  = 3'd4,
        PH_OKEY     = 3'd5,
        PH_OKEY_RUN = 3'd6,
        PH_FINISH   = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        SEG_NONE = 2'd0,
        SEG_IKEY = 2'd1,
        SEG_MSG  = 2'd2,
        SEG_OKEY = 2'd3
    } seg_e;

    typedef struct packed {
        logic       hmac;
        logic [1:0] algo;
        logic       long_key;
    } job_cfg_t;

    function automatic logic phase_accepts(phase_e p);
        return (p == PH_IKEY) || (p == PH_MSG) || (p == PH_OKEY);
    endfunction

    function automatic logic phase_running(phase_e p);
        return (p == PH_IKEY_RUN) || (p == PH_MSG_RUN) || (p == PH_OKEY_RUN);
    endfunction

    function automatic seg_e phase_seg(phase_e p);
        case (p)
            PH_IKEY, PH_IKEY_RUN: return SEG_IKEY;
            PH_MSG,  PH_MSG_RUN:  return SEG_MSG;
            PH_OKEY, PH_OKEY_RUN: return SEG_OKEY;
            default:              return SEG_NONE;
        endcase
    endfunction

    function automatic phase_e run_of(phase_e p);
        case (p)
            PH_IKEY: return PH_IKEY_RUN;
            PH_MSG:  return PH_MSG_RUN;
            PH_OKEY: return PH_OKEY_RUN;
            default: return p;
        endcase
    endfunction

    function automatic phase_e after_run(phase_e p, logic hmac);
        case (p)
            PH_IKEY_RUN: return PH_MSG;
            PH_MSG_RUN:  return hmac ? PH_OKEY : PH_FINISH;
            PH_OKEY_RUN: return PH_FINISH;
            default:     return p;
        endcase
    endfunction

    function automatic int unsigned digest_words(logic [1:0] algo, int unsigned short_n,
                                                 int unsigned long_n);
        return algo[1] ? long_n : short_n;
    endfunction

endpackage

// File: rtl/hmacseq_wordpath.sv
module hmacseq_wordpath #(
    parameter int DATA_W = 32,
    parameter int BITS_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              accept,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic              close,
    input  logic [BITS_W-1:0] bits,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic [BITS_W-1:0] out_bits
);
    logic              hold_v;
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            hold_v    <= 1'b0;
            hold_q    <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            if (accept && close) begin
                out_valid <= hold_v;
                out_data  <= hold_q;
                out_last  <= 1'b1;
                out_bits  <= bits;
                hold_v    <= 1'b0;
            end else if (accept && wr) begin
                if (hold_v) begin
                    out_valid <= 1'b1;
                    out_data  <= hold_q;
                end
                hold_q <= data;
                hold_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hmacseq_phase_fsm.sv
module hmacseq_phase_fsm
    import hmacseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     init,
    input  job_cfg_t cfg_in,
    input  logic     close,
    input  logic     eng_done,
    output phase_e   phase,
    output job_cfg_t cfg,
    output logic     seg_start,
    output logic     final_done
);
    phase_e ph_nx;
    logic   start_nx;

    always_comb begin
        ph_nx      = phase;
        start_nx   = 1'b0;
        final_done = 1'b0;
        if (init) begin
            ph_nx    = cfg_in.hmac ? PH_IKEY : PH_MSG;
            start_nx = 1'b1;
        end else if (phase_accepts(phase) && close) begin
            ph_nx = run_of(phase);
        end else if (phase_running(phase) && eng_done) begin
            ph_nx      = after_run(phase, cfg.hmac);
            start_nx   = phase_accepts(ph_nx);
            final_done = (ph_nx == PH_FINISH);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            cfg       <= '0;
            seg_start <= 1'b0;
        end else begin
            phase     <= ph_nx;
            seg_start <= start_nx;
            if (init) cfg <= cfg_in;
        end
    end
endmodule

// File: rtl/hmacseq_digest_cap.sv
module hmacseq_digest_cap
    import hmacseq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int MAX_WORDS   = 8,
    parameter int SHORT_WORDS = 5,
    localparam int DIG_W      = DATA_W * MAX_WORDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             capture,
    input  logic [1:0]       algo,
    input  logic [DIG_W-1:0] eng_digest,
    output logic [DIG_W-1:0] digest,
    output logic             done
);
    int unsigned n_keep;
    assign n_keep = digest_words(algo, SHORT_WORDS, MAX_WORDS);

    for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                digest[i*DATA_W +: DATA_W] <= '0;
            end else if (capture) begin
                digest[i*DATA_W +: DATA_W] <= (i < n_keep) ? eng_digest[i*DATA_W +: DATA_W] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) done <= 1'b0;
        else if (capture) done <= 1'b1;
    end
endmodule

// File: rtl/hmac_seq_ctrl.sv
module hmac_seq_ctrl
    import hmacseq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int MAX_WORDS   = 8,
    parameter int SHORT_WORDS = 5,
    localparam int BITS_W     = $clog2(DATA_W) + 1,
    localparam int DIG_W      = DATA_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_init,
    input  logic              cfg_hmac,
    input  logic [1:0]        cfg_algo,
    input  logic              cfg_long_key,
    input  logic              din_wr,
    input  logic [DATA_W-1:0] din_data,
    input  logic              seg_go,
    input  logic [BITS_W-1:0] seg_bits,
    output logic              rdy,
    output logic              busy,
    output logic              done,
    output logic [DIG_W-1:0]  digest,
    output logic              eng_start,
    output logic [1:0]        eng_seg,
    output logic [1:0]        eng_algo,
    output logic              eng_key_long,
    output logic              eng_valid,
    output logic [DATA_W-1:0] eng_data,
    output logic              eng_last,
    output logic [BITS_W-1:0] eng_bits,
    input  logic              eng_done,
    input  logic [DIG_W-1:0]  eng_digest
);
    phase_e   phase;
    job_cfg_t cfg;
    job_cfg_t cfg_req;
    logic     final_done;
    seg_e     seg;

    assign cfg_req = '{hmac: cfg_hmac, algo: cfg_algo, long_key: cfg_long_key};

    hmacseq_phase_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .init       (cfg_init),
        .cfg_in     (cfg_req),
        .close      (seg_go),
        .eng_done   (eng_done),
        .phase      (phase),
        .cfg        (cfg),
        .seg_start  (eng_start),
        .final_done (final_done)
    );

    assign rdy  = phase_accepts(phase);
    assign busy = phase_running(phase);
    assign seg  = phase_seg(phase);

    hmacseq_wordpath #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_words (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_init),
        .accept    (rdy),
        .wr        (din_wr),
        .data      (din_data),
        .close     (seg_go),
        .bits      (seg_bits),
        .out_valid (eng_valid),
        .out_data  (eng_data),
        .out_last  (eng_last),
        .out_bits  (eng_bits)
    );

    hmacseq_digest_cap #(
        .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .SHORT_WORDS(SHORT_WORDS)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .clear      (cfg_init),
        .capture    (final_done),
        .algo       (cfg.algo),
        .eng_digest (eng_digest),
        .digest     (digest),
        .done       (done)
    );

    assign eng_seg      = seg;
    assign eng_algo     = cfg.algo;
    assign eng_key_long = cfg.long_key && ((seg == SEG_IKEY) || (seg == SEG_OKEY));
endmodule

// File: rtl/hmac_seq_ctrl_chk.sv
module hmac_seq_ctrl_chk #(
    parameter int DATA_W      = 32,
    parameter int MAX_WORDS   = 8,
    parameter int SHORT_WORDS = 5,
    localparam int DIG_W      = DATA_W * MAX_WORDS
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_init,
    input logic             seg_go,
    input logic             rdy,
    input logic             busy,
    input logic             done,
    input logic [DIG_W-1:0] digest,
    input logic [1:0]       eng_seg,
    input logic [1:0]       eng_algo,
    input logic             eng_key_long,
    input logic             eng_valid,
    input logic             eng_last,
    input logic             eng_done
);
    AST_RDY_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rdy && busy)); // R6
    AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (rst)
        (seg_go && rdy && !cfg_init) |=> busy); // R6
    AST_NO_WORD_UNREADY: assert property (@(posedge clk) disable iff (rst)
        eng_valid |-> $past(rdy)); // R4
    AST_LAST_GOES_BUSY: assert property (@(posedge clk) disable iff (rst)
        eng_last |-> busy); // R3
    AST_LONG_ONLY_KEYS: assert property (@(posedge clk) disable iff (rst)
        eng_key_long |-> (eng_seg == 2'd1 || eng_seg == 2'd3)); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!rdy && !busy)); // R9
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_init) |=> (done && $stable(digest))); // R9
    AST_SHORT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !eng_algo[1] |-> (digest[DIG_W-1:SHORT_WORDS*DATA_W] == '0)); // R9
    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cfg_init |=> (!done && !busy && rdy && digest == '0)); // R10
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        (!busy && eng_done && !cfg_init && !seg_go) |=> ($stable(digest) && $stable(eng_seg))); // R11
endmodule

bind hmac_seq_ctrl hmac_seq_ctrl_chk #(
    .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS), .SHORT_WORDS(SHORT_WORDS)
) u_chk (
    .clk(clk), .rst(rst), .cfg_init(cfg_init), .seg_go(seg_go), .rdy(rdy), .busy(busy),
    .done(done), .digest(digest), .eng_seg(eng_seg), .eng_algo(eng_algo),
    .eng_key_long(eng_key_long), .eng_valid(eng_valid), .eng_last(eng_last),
    .eng_done(eng_done)
);

// File: tb/hmac_seq_ctrl_bench.sv
module hmac_seq_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int NW = 8;
    localparam int SW = 5;
    localparam int BW = 6;
    localparam int DGW = DW * NW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_init = 0, cfg_hmac = 0, cfg_long_key = 0;
    logic [1:0] cfg_algo = 0;
    logic din_wr = 0, seg_go = 0;
    logic [DW-1:0] din_data = 0;
    logic [BW-1:0] seg_bits = 0;
    logic rdy, busy, done, eng_start, eng_key_long, eng_valid, eng_last, eng_done;
    logic [DGW-1:0] digest, eng_digest;
    logic [1:0] eng_seg, eng_algo;
    logic [DW-1:0] eng_data;
    logic [BW-1:0] eng_bits;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmac_seq_ctrl u_hmac_seq_ctrl (
        .clk(clk), .rst(rst), .cfg_init(cfg_init), .cfg_hmac(cfg_hmac), .cfg_algo(cfg_algo),
        .cfg_long_key(cfg_long_key), .din_wr(din_wr), .din_data(din_data), .seg_go(seg_go),
        .seg_bits(seg_bits), .rdy(rdy), .busy(busy), .done(done), .digest(digest),
        .eng_start(eng_start), .eng_seg(eng_seg), .eng_algo(eng_algo),
        .eng_key_long(eng_key_long), .eng_valid(eng_valid), .eng_data(eng_data),
        .eng_last(eng_last), .eng_bits(eng_bits), .eng_done(eng_done), .eng_digest(eng_digest)
    );

    // stand-in engine
    logic [31:0] m_acc;
    logic [7:0]  m_cnt;
    logic [BW-1:0] m_bits;
    logic [1:0]  m_lastseg;
    logic [3:0]  m_cd;
    logic        m_done, spur_done;
    int          lat = 2;
    int          tot_valid;

    always @(posedge clk) begin
        if (rst) begin
            m_acc <= 0; m_cnt <= 0; m_bits <= 0; m_cd <= 0; m_done <= 0; m_lastseg <= 0;
            tot_valid <= 0;
        end else begin
            m_done <= 1'b0;
            if (eng_start) begin
                m_acc <= 0; m_cnt <= 0;
            end else if (eng_valid) begin
                m_acc <= {m_acc[30:0], m_acc[31]} ^ eng_data;
                m_cnt <= m_cnt + 8'd1;
            end
            if (eng_valid) tot_valid <= tot_valid + 1;
            if (eng_last) begin
                m_bits <= eng_bits; m_cd <= 4'(lat); m_lastseg <= eng_seg;
            end else if (m_cd != 0) begin
                m_cd <= m_cd - 4'd1;
                if (m_cd == 4'd1) m_done <= 1'b1;
            end
        end
    end

    assign eng_done = m_done | spur_done;
    always_comb begin
        for (int i = 0; i < NW; i++)
            eng_digest[i*DW +: DW] = m_acc ^ {m_cnt, 2'b00, m_bits, 16'(i)};
    end

    int checks = 0, failures = 0;
    logic [31:0] wl [0:15];
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [DGW-1:0] act,
                       input logic [DGW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_init(input bit h, input logic [1:0] a, input bit l);
        cfg_hmac = h; cfg_algo = a; cfg_long_key = l; cfg_init = 1;
        tick(); cfg_init = 0;
    endtask

    task automatic push(input logic [31:0] w);
        din_wr = 1; din_data = w; tick(); din_wr = 0;
    endtask

    task automatic go(input logic [BW-1:0] b);
        seg_go = 1; seg_bits = b; tick(); seg_go = 0;
    endtask

    task automatic wait_free(input string req);
        int n = 0;
        while (busy && n < 40) begin tick(); n++; end
        chk(!busy, req, DGW'(busy), 0);
    endtask

    function automatic logic [DGW-1:0] expect_dig(int n, logic [BW-1:0] b, logic [1:0] a);
        logic [31:0] acc = 0;
        logic [DGW-1:0] r = '0;
        int nk;
        for (int i = 0; i < n; i++) acc = {acc[30:0], acc[31]} ^ wl[i];
        nk = a[1] ? NW : SW;
        for (int i = 0; i < nk; i++) r[i*DW +: DW] = acc ^ {8'(n), 2'b00, b, 16'(i)};
        return r;
    endfunction

    task automatic send_seg(input int n, input logic [31:0] base, input logic [BW-1:0] b);
        for (int i = 0; i < n; i++) begin
            wl[i] = base ^ (32'h9e3779b9 * (i + 1));
            push(wl[i]);
        end
        go(b);
    endtask

    task automatic run_job(input bit h, input logic [1:0] a, input bit l, input int nm);
        logic [BW-1:0] b;
        int nk;
        nk = l ? 3 : 2;
        do_init(h, a, l);
        chk(rdy && eng_start, "R2 ready+start", {rdy, eng_start}, 2'b11);
        chk(eng_seg == (h ? 2'd1 : 2'd2), "R2 first seg", eng_seg, h ? 2'd1 : 2'd2);
        if (h) begin
            chk(eng_key_long == l, "R8 inner key flag", eng_key_long, l);
            send_seg(nk, 32'h1000_0000 + a, 6'd32);
            chk(busy && !rdy, "R6 busy after go", {busy, rdy}, 2'b10);
            wait_free("R6 inner done");
            chk(m_cnt == 8'(nk) && m_lastseg == 2'd1, "R3 inner words",
                {m_cnt, m_lastseg}, {8'(nk), 2'd1});
            chk(eng_seg == 2'd2 && rdy && eng_start, "R7 to message",
                {eng_seg, rdy, eng_start}, {2'd2, 2'b11});
        end
        chk(eng_key_long == 1'b0, "R8 msg flag", eng_key_long, 0);
        b = 6'(8 * nm);
        send_seg(nm, 32'h2000_0000 + {a, nm[3:0]}, b);
        wait_free("R6 msg done");
        chk(m_cnt == 8'(nm), "R3 msg words", m_cnt, nm);
        if (h) begin
            chk(eng_seg == 2'd3 && rdy && !done, "R7 to outer", {eng_seg, rdy, done},
                {2'd3, 2'b10});
            chk(eng_key_long == l, "R8 outer key flag", eng_key_long, l);
            b = 6'd24;
            send_seg(nk, 32'h3000_0000 + l, b);
            wait_free("R6 outer done");
            chk(digest == expect_dig(nk, b, a), "R9 hmac digest", digest, expect_dig(nk, b, a));
        end else begin
            chk(digest == expect_dig(nm, b, a), "R9 plain digest", digest, expect_dig(nm, b, a));
        end
        chk(done && !rdy, "R9 done flag", {done, rdy}, 2'b10);
    endtask

    initial begin
        logic [DGW-1:0] keep;
        spur_done = 0;
        repeat (3) tick();
        rst = 0;
        tick();
        chk(!rdy && !busy && !done && !eng_valid && !eng_last && !eng_start,
            "R1 reset flags", {rdy, busy, done, eng_valid, eng_last, eng_start}, 0);
        chk(digest == '0 && eng_seg == 0, "R1 reset digest", digest, 0);

        push(32'hdead0001); push(32'hdead0002); go(6'd32);
        tick();
        chk(tot_valid == 0 && !busy, "R4 idle writes", tot_valid, 0);

        for (int h = 0; h < 2; h++)
            for (int a = 0; a < 4; a++)
                for (int l = 0; l < 2; l++)
                    for (int nm = 1; nm <= 3; nm++) begin
                        lat = 1 + (a + nm) % 4;
                        run_job(h[0], a[1:0], l[0], nm);
                    end

        keep = digest;
        push(32'h5555_aaaa); tick();
        chk(digest == keep && done, "R4 writes after finish", digest, keep);
        spur_done = 1; tick(); spur_done = 0; tick();
        chk(digest == keep && done, "R11 stray done in finish", digest, keep);

        do_init(0, 2'd0, 0);
        chk(!done && digest == '0, "R10 init clears result", digest, 0);
        spur_done = 1; tick(); spur_done = 0; tick();
        chk(rdy && eng_seg == 2'd2, "R11 stray done while ready", {rdy, eng_seg}, 3'b110);

        lat = 6;
        do_init(1, 2'd2, 0);
        wl[0] = 32'h0bad_0bad; push(wl[0]); go(6'd32);
        push(32'hffff_0000);
        chk(busy, "R4 write during busy", busy, 1);
        wait_free("R6 busy end");
        wl[0] = 32'h0000_1111; wl[1] = 32'h0000_2222;
        push(wl[0]); push(wl[1]); go(6'd16);
        wait_free("R6 msg end");
        chk(m_cnt == 8'd2, "R4 busy write discarded", m_cnt, 2);

        lat = 5;
        do_init(1, 2'd0, 1);
        push(32'h7777_0001); push(32'h7777_0002); go(6'd32);
        tick();
        do_init(0, 2'd3, 0);
        chk(!busy && rdy && eng_seg == 2'd2 && !eng_key_long, "R10 abort while busy",
            {busy, rdy, eng_seg, eng_key_long}, 5'b01100);
        repeat (8) tick();
        chk(!busy && rdy, "R10 old done ignored", {busy, rdy}, 2'b01);

        do_init(0, 2'd1, 0);
        push(32'h4444_0000);
        do_init(0, 2'd1, 0);
        wl[0] = 32'h1234_5678; wl[1] = 32'h8765_4321;
        push(wl[0]); push(wl[1]); go(6'd4);
        wait_free("R10 run");
        chk(digest == expect_dig(2, 6'd4, 2'd1), "R10 held word flushed", digest,
            expect_dig(2, 6'd4, 2'd1));

        do_init(0, 2'd3, 0);
        wl[0] = 32'haaaa_0001; wl[1] = 32'haaaa_0002;
        push(wl[0]); push(wl[1]);
        din_wr = 1; din_data = 32'hcccc_cccc; seg_go = 1; seg_bits = 6'd32;
        tick(); din_wr = 0; seg_go = 0;
        wait_free("R5 run");
        chk(m_cnt == 8'd2, "R5 concurrent write dropped", m_cnt, 2);
        chk(digest == expect_dig(2, 6'd32, 2'd3), "R5 digest", digest, expect_dig(2, 6'd32, 2'd3));

        do_init(0, 2'd0, 0);
        go(6'd8);
        wait_free("R3 empty seg");
        chk(done && m_cnt == 0, "R3 empty segment closes", {done, m_cnt}, {1'b1, 8'd0});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule